// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Bank

This block holds the configuration words of a five-window display compositor. Every word exists twice: a staging copy that the register port writes and reads, and a live copy that drives the timing and pixel fetch logic. Live copies change only on a frame boundary. A small commit sequencer watches the vertical sync input, and on each rising edge of that input it copies the staging set of every window into its live set in a single cycle.

Each window has a hold bit. While a window's hold bit is set, a frame boundary leaves that window's live copy as it is, so software can rewrite position, size and format over several bus writes and the hardware never runs with a half-changed set. Once the hold bit is cleared, the pending staging values go live at the next frame boundary, not at the moment of clearing. Each window also has a fetch channel enable, kept in the same control word as the hold bits and applied directly. Window 0 has no blend or colour key words. Windows 1 to 4 have both.

The sequencer has three states. IDLE waits for vsync high and moves to COMMIT. COMMIT lasts one cycle, raises the internal commit strobe and always moves to WAIT_LOW. WAIT_LOW stays while vsync is high and returns to IDLE once it is low.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset every staging word, every live word, every hold bit and every channel enable reads zero.
- R2: A write to word slot s (0..6) of window w at word address w*8+s shows up on rd_data the cycle after the write edge, with rd_addr set to that address. Slots: 0 window control (bit 0 = window on), 1 top-left, 2 bottom-right, 3 area, 4 blend, 5 key control, 6 key value.
- R3: A staging value reaches act_cfg (word (w*7+s), 32 bits each) only on a frame boundary: if vsync is first sampled high at edge k, live copies load at edge k+1 and not earlier.
- R4: A window whose hold bit is set at the load edge keeps its live copy; windows whose hold bit is clear load as usual at that edge.
- R5: Clearing a hold bit does not change the live copy; the pending staging values load at the next frame boundary after the clear.
- R6: The control word at address 40 holds the hold bits in bits 4:0 (bit w for window w) and channel enables in bits 12:8; a write updates win_protect and chan_enable at the write edge, and a read returns them in the same positions.
- R7: Window 0 has no slots 4 to 6: writes there are dropped, reads return zero and its live slots 4 to 6 stay zero.
- R8: The disable sequence (set hold and keep channel, clear window on, then clear hold and channel in one write) drops chan_enable at that last write while the live window-on bit stays set until the following frame boundary.
- R9: vsync held high for many cycles produces exactly one load; writes made while it stays high wait for the next rising edge of vsync.
- R10: Addresses that map to no word (slot 7 of any window, and anything above 40) read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync | input | 1 | Vertical sync level from the timing generator |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Word address of the read |
| rd_data | output | 32 | Staging value at rd_addr (combinational) |
| win_protect | output | 5 | Hold bit per window |
| chan_enable | output | 5 | Fetch channel enable per window |
| act_cfg | output | 1120 | All live words, word (w*7+s) at bits 32*(w*7+s) upward |

## Verification
Random writes over the whole address space, mixed with random control words and frame boundaries, compare staging reads and live copies against a model; this separates the staging path from the load path and catches any decode that leaks into unmapped or missing words. Directed runs pin the load to the exact edge after vsync, hold one window while a neighbour loads, clear a hold with no frame boundary following, walk the disable sequence, and keep vsync high across writes, which tells a level-triggered commit from an edge-triggered one.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    // commit sequencer states
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_COMMIT   = 2'd1,
        S_WAIT_LOW = 2'd2
    } commit_state_t;

    // word slots inside one window's address block
    localparam int SLOTS_PER_WIN = 7;
    localparam int SLOT_BITS     = 3;
    localparam int FIRST_EXTRA   = 4;   // slots from here on exist only with blend/key support
    localparam int CHAN_LSB      = 8;   // channel enables start here in the control word

endpackage

// File: rtl/commit_fsm.sv
module commit_fsm
    import shadow_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic commit_go
);

    commit_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (vsync) state_d = S_COMMIT;
            S_COMMIT:   state_d = S_WAIT_LOW;
            S_WAIT_LOW: if (!vsync) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        commit_go = (state_q == S_COMMIT);
    end

endmodule

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import shadow_bank_pkg::*;
#(
    parameter int DW        = 32,
    parameter bit HAS_EXTRA = 1'b1,
    localparam int FLAT_W   = SLOTS_PER_WIN * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_BITS-1:0] wr_slot,
    input  logic [DW-1:0]        wr_data,
    input  logic                 load,
    output logic [FLAT_W-1:0]    soft_flat,
    output logic [FLAT_W-1:0]    act_flat
);

    for (genvar s = 0; s < SLOTS_PER_WIN; s++) begin : g_slot
        if ((s < FIRST_EXTRA) || HAS_EXTRA) begin : g_present
            logic [DW-1:0] soft_q, act_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    soft_q <= '0;
                end else if (wr_en && (wr_slot == SLOT_BITS'(s))) begin
                    soft_q <= wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_q <= '0;
                end else if (load) begin
                    act_q <= soft_q;
                end
            end

            assign soft_flat[s*DW +: DW] = soft_q;
            assign act_flat[s*DW +: DW]  = act_q;
        end else begin : g_absent
            assign soft_flat[s*DW +: DW] = '0;
            assign act_flat[s*DW +: DW]  = '0;
        end
    end

endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN   = 5,
    parameter int DW        = 32,
    localparam int AW       = $clog2(NUM_WIN * 8 + 1),
    localparam int WIN_W    = SLOTS_PER_WIN * DW,
    localparam int ALL_W    = NUM_WIN * WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NUM_WIN-1:0] win_protect,
    output logic [NUM_WIN-1:0] chan_enable,
    output logic [ALL_W-1:0]   act_cfg
);

    localparam int SELW      = AW - SLOT_BITS;
    localparam int CTRL_ADDR = NUM_WIN * 8;

    logic                 commit_go;
    logic [ALL_W-1:0]     soft_all;
    logic [NUM_WIN-1:0]   prot_q, chan_q;
    logic [SELW-1:0]      wr_win, rd_win;
    logic [SLOT_BITS-1:0] wr_slot, rd_slot;
    logic                 ctrl_hit;

    assign wr_win  = wr_addr[AW-1:SLOT_BITS];
    assign wr_slot = wr_addr[SLOT_BITS-1:0];
    assign rd_win  = rd_addr[AW-1:SLOT_BITS];
    assign rd_slot = rd_addr[SLOT_BITS-1:0];
    assign ctrl_hit = wr_en && (wr_addr == AW'(CTRL_ADDR));

    commit_fsm u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .commit_go (commit_go)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic win_wr;
        assign win_wr = wr_en && (wr_win == SELW'(w)) &&
                        (wr_slot < SLOT_BITS'(SLOTS_PER_WIN));

        win_cfg_regs #(
            .DW        (DW),
            .HAS_EXTRA (w != 0)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (win_wr),
            .wr_slot   (wr_slot),
            .wr_data   (wr_data),
            .load      (commit_go && !prot_q[w]),
            .soft_flat (soft_all[w*WIN_W +: WIN_W]),
            .act_flat  (act_cfg[w*WIN_W +: WIN_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '0;
            chan_q <= '0;
        end else if (ctrl_hit) begin
            prot_q <= wr_data[NUM_WIN-1:0];
            chan_q <= wr_data[CHAN_LSB +: NUM_WIN];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(CTRL_ADDR)) begin
            rd_data[NUM_WIN-1:0]          = prot_q;
            rd_data[CHAN_LSB +: NUM_WIN]  = chan_q;
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if ((rd_win == SELW'(w)) && (rd_slot < SLOT_BITS'(SLOTS_PER_WIN))) begin
                    rd_data = soft_all[(w*SLOTS_PER_WIN + int'(rd_slot))*DW +: DW];
                end
            end
        end
    end

    assign win_protect = prot_q;
    assign chan_enable = chan_q;

endmodule

// File: rtl/shadow_bank_checker.sv
module shadow_bank_checker
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int DW      = 32,
    localparam int WIN_W  = SLOTS_PER_WIN * DW,
    localparam int ALL_W  = NUM_WIN * WIN_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_hit,
    input logic [NUM_WIN-1:0] prot_wr,
    input logic [NUM_WIN-1:0] chan_wr,
    input logic [NUM_WIN-1:0] win_protect,
    input logic [NUM_WIN-1:0] chan_enable,
    input logic [ALL_W-1:0]   act_cfg,
    input logic [ALL_W-1:0]   soft_cfg,
    input logic               commit_go
);

    // R1: the first sampled cycle out of reset shows a cleared bank
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_cfg == '0 && win_protect == '0 && chan_enable == '0));

    // R3: live copies move only after a commit strobe
    p_no_load_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_go |=> $stable(act_cfg));

    // R9: the commit strobe lasts one cycle
    p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> !commit_go);

    // R6: control writes land on the hold and channel outputs
    p_ctrl_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> (win_protect == $past(prot_wr) && chan_enable == $past(chan_wr)));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_chk
        // R4: a held window keeps its live copy through a commit
        p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_go && win_protect[w]) |=> $stable(act_cfg[w*WIN_W +: WIN_W]));

        // R3: an unheld window takes its staging copy at the commit
        p_commit_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_go && !win_protect[w]) |=>
                (act_cfg[w*WIN_W +: WIN_W] == $past(soft_cfg[w*WIN_W +: WIN_W])));
    end

endmodule

bind shadow_reg_bank shadow_bank_checker #(
    .NUM_WIN (NUM_WIN),
    .DW      (DW)
) u_shadow_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_hit    (ctrl_hit),
    .prot_wr     (wr_data[NUM_WIN-1:0]),
    .chan_wr     (wr_data[shadow_bank_pkg::CHAN_LSB +: NUM_WIN]),
    .win_protect (win_protect),
    .chan_enable (chan_enable),
    .act_cfg     (act_cfg),
    .soft_cfg    (soft_all),
    .commit_go   (commit_go)
);

// File: tb/test_shadow_reg_bank.sv
module test_shadow_reg_bank;

    localparam int NW    = 5;
    localparam int DW    = 32;
    localparam int NS    = 7;
    localparam int AW    = 6;
    localparam int CTRL  = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vsync = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NW-1:0]   win_protect, chan_enable;
    logic [NW*NS*DW-1:0] act_cfg;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] soft_m [NW][NS];
    logic [DW-1:0] act_m  [NW][NS];
    logic [NW-1:0] prot_m = '0;
    logic [NW-1:0] chan_m = '0;

    always #10 clk = ~clk;

    shadow_reg_bank i_shadow_reg_bank (
        .clk(clk), .rst_n(rst_n), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .win_protect(win_protect), .chan_enable(chan_enable),
        .act_cfg(act_cfg)
    );

    function automatic bit slot_ok(int w, int s);
        return (w < NW) && (s < NS) && !(w == 0 && s >= 4);
    endfunction

    function automatic logic [DW-1:0] exp_read(int a);
        logic [DW-1:0] v = '0;
        if (a == CTRL) begin
            v[4:0]  = prot_m;
            v[12:8] = chan_m;
        end else if (slot_ok(a / 8, a % 8)) begin
            v = soft_m[a/8][a%8];
        end
        return v;
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == CTRL) begin
            prot_m = d[4:0];
            chan_m = d[12:8];
        end else if (slot_ok(a / 8, a % 8)) begin
            soft_m[a/8][a%8] = d;
        end
    endtask

    task automatic model_commit();
        for (int w = 0; w < NW; w++)
            if (!prot_m[w])
                for (int s = 0; s < NS; s++) act_m[w][s] = soft_m[w][s];
    endtask

    // vsync high for 'hi' cycles (hi >= 2), then low long enough to re-arm
    task automatic frame(int hi);
        @(negedge clk); vsync = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_commit();
        for (int i = 2; i < hi; i++) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_reads(string req);
        for (int a = 0; a < 64; a++) begin
            rd_addr = AW'(a);
            #1;
            chk(req, rd_data, exp_read(a));
        end
    endtask

    task automatic check_active(string req);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++)
                chk(req, act_cfg[(w*NS+s)*DW +: DW], act_m[w][s]);
    endtask

    task automatic check_ctrl(string req);
        chk(req, DW'(win_protect), DW'(prot_m));
        chk(req, DW'(chan_enable), DW'(chan_m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        process::self().srandom(32'd20240611);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                soft_m[w][s] = '0; act_m[w][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared after reset
        check_reads("R1");
        check_active("R1");
        check_ctrl("R1");

        // R2: write then read back
        wr(2*8+1, 32'h0012_0034);
        wr(4*8+6, 32'hCAFE_0006);
        rd_addr = AW'(2*8+1); #1;
        chk("R2", rd_data, 32'h0012_0034);
        check_reads("R2");
        check_active("R3 before frame");

        // R3: exact load edge
        @(negedge clk); vsync = 1'b1;
        @(negedge clk);  // edge k: commit state entered, no load yet
        chk("R3 not before k+1", act_cfg[(2*NS+1)*DW +: DW], 32'h0);
        @(negedge clk);  // edge k+1: load
        model_commit();
        chk("R3 at k+1", act_cfg[(2*NS+1)*DW +: DW], 32'h0012_0034);
        vsync = 1'b0;
        @(negedge clk); @(negedge clk);
        check_active("R3");

        // R7: window 0 has no blend/key words
        wr(4, 32'hFFFF_FFFF); wr(5, 32'h1111_1111); wr(6, 32'h2222_2222);
        rd_addr = AW'(5); #1;
        chk("R7 read", rd_data, 32'h0);
        frame(2);
        chk("R7 live", act_cfg[(0*NS+6)*DW +: DW], 32'h0);
        check_active("R7");

        // R10: unmapped addresses
        wr(7, 32'hDEAD_0007); wr(1*8+7, 32'hDEAD_0015); wr(41, 32'hDEAD_0029); wr(63, 32'hDEAD_003F);
        check_reads("R10");
        frame(2);
        check_active("R10");

        // R6: control word fields
        wr(CTRL, 32'h0000_1F15);
        check_ctrl("R6");
        rd_addr = AW'(CTRL); #1;
        chk("R6 read", rd_data, 32'h0000_1F15);
        wr(CTRL, 32'h0);
        check_ctrl("R6");

        // R4 and R5: hold window 1 while window 3 loads
        wr(CTRL, 32'h0000_0002);
        wr(1*8+2, 32'h0100_0200);
        wr(3*8+2, 32'h0300_0400);
        frame(2);
        chk("R4 held", act_cfg[(1*NS+2)*DW +: DW], 32'h0);
        chk("R4 free", act_cfg[(3*NS+2)*DW +: DW], 32'h0300_0400);
        check_active("R4");
        wr(CTRL, 32'h0);
        repeat (4) @(negedge clk);
        chk("R5 no load at clear", act_cfg[(1*NS+2)*DW +: DW], 32'h0);
        frame(2);
        chk("R5 load next frame", act_cfg[(1*NS+2)*DW +: DW], 32'h0100_0200);
        check_active("R5");

        // R8: disable sequence for window 2
        wr(CTRL, 32'h0000_0400);
        wr(2*8+0, 32'h1);
        frame(2);
        chk("R8 on", act_cfg[(2*NS)*DW +: DW], 32'h1);
        wr(CTRL, 32'h0000_0404);
        wr(2*8+0, 32'h0);
        frame(2);
        chk("R8 still on under hold", act_cfg[(2*NS)*DW +: DW], 32'h1);
        wr(CTRL, 32'h0);
        chk("R8 chan off", DW'(chan_enable), 32'h0);
        chk("R8 on until frame", act_cfg[(2*NS)*DW +: DW], 32'h1);
        frame(2);
        chk("R8 off", act_cfg[(2*NS)*DW +: DW], 32'h0);
        check_active("R8");

        // R9: long vsync gives one load
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); @(negedge clk);
        model_commit();
        wr(4*8+3, 32'h0004_4444);
        repeat (5) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 single load", act_cfg[(4*NS+3)*DW +: DW], 32'h0);
        check_active("R9");
        frame(6);
        chk("R9 next edge", act_cfg[(4*NS+3)*DW +: DW], 32'h0004_4444);

        // random mix: R2 R3 R4 R6 R10
        for (int i = 0; i < 300; i++) begin
            int op = int'($urandom % 8);
            if (op == 0) begin
                frame(2 + int'($urandom % 3));
                check_active("R3/R4 random");
            end else if (op == 1) begin
                wr(CTRL, $urandom & 32'h0000_1F1F);
                check_ctrl("R6 random");
            end else begin
                wr(int'($urandom % 64), $urandom);
            end
            if (i % 50 == 0) check_reads("R2/R10 random");
        end
        wr(CTRL, 32'h0);
        frame(2);
        check_active("R3 final");
        check_reads("R2 final");

        finish_up();
    end

endmodule